// File: doc/BRIEF.md
# Frame-Multiplexed Codec Serial Port

This block is the device-side serial port of a modem analog front end. A host acting as master sends a frame-sync pulse, then clocks sixteen bits in each direction. Each frame does one of two jobs. A data frame swaps one outgoing sample for one incoming sample. A control frame reads or writes one byte in a small register file. The serial clock is the block clock. The transmit sample taken from the host is presented as a parallel word with a one-cycle strobe. The receive sample sent to the host is taken from a parallel input.

The port decides on its own whether the next frame is data or control, and it has two ways of doing so. In the default software-request mode, a data frame whose low bit is 1 makes the next frame a control frame, and every other frame is data. When a mode bit in register 0x01 is set, data and control frames strictly alternate. The host can always get back to software-request mode by sending the same "clear mode bit" word in two frames in a row, even if it has lost track of the frame phase.

Top module: `fmux_serial_port`

## Requirements
- R1: A frame starts with `fs` high for one clock. The sixteen bit times follow on the next sixteen clocks, most significant bit first. `sdin` is captured on those sixteen rising edges, and `sdout` carries the matching outgoing bit in the cycle before each of those edges.
- R2: When a data frame ends, the received 16-bit word appears on `tx_sample`, and `tx_valid` is high for exactly the one cycle after the last bit edge. A control frame raises no strobe.
- R3: In a data frame, `sdout` sends the value `rx_sample` had on the `fs` clock edge.
- R4: A control frame on `sdin` holds bit 15 as read/write (1 = read, 0 = write), bits 14:8 as the register address, and bits 7:0 as write data. A write takes effect at the end of the frame.
- R5: In a control frame, `sdout` sends eight zero bits and then the addressed register's contents as they were before this frame.
- R6: A read leaves every register unchanged, and its data bits 7:0 have no effect.
- R7: In software-request mode, a data frame makes the next frame a control frame only if its bit 0 is 1. Otherwise the next frame is data. A control frame is always followed by a data frame.
- R8: While bit 0 of register 0x01 is 1, every data frame is followed by a control frame, whatever the data word's bit 0 is.
- R9: Two frames in a row carrying word 0x0100 (write 0x00 to register 0x01) leave the port in software-request mode, whichever phase it was in before.
- R10: After reset the registers hold: 0x00=0x08, 0x02=0xFF, 0x03=0xFF, 0x06=0x50, 0x09=0x0A, 0x0A=0x22, 0x0B=0x12, 0x0D=0xC0. Every other implemented register (0x01 to 0x0E) holds 0x00.
- R11: Bits 7:4 of register 0x06 always read 0x5. Writes change only bits 3:0 of that register.
- R12: Addresses 0x0F and above read as 0x00 and ignore writes.
- R13: Reset leaves `tx_valid` and `sdout` at 0 and puts the port in software-request mode, so the first frame is a data frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fs | input | 1 | Frame-sync pulse, one clock before the first bit |
| sdin | input | 1 | Serial data from host |
| sdout | output | 1 | Serial data to host |
| rx_sample | input | 16 | Receive sample to send in the next data frame |
| tx_sample | output | 16 | Last transmit sample received in a data frame |
| tx_valid | output | 1 | One-cycle strobe marking a new `tx_sample` |

## Verification
The bench runs a reference model of the frame-phase rule next to the design. It goes after the points where a data word looks like a register write. A port that ignored the low-bit request or the alternation bit would treat the following frame as data: a strobe would appear where none is due, the register would not change, and the returned word would be wrong. Recovery is tried from both phases, so a port that needs the clear word in a particular phase stays in alternation and returns garbage on a later read. Reads that carry nonzero data bits, writes to the revision nibble, and accesses above the register range show up at once as a wrong read-back value. A port that took the read address one bit early or late would also return the wrong register.

// File: rtl/fsp_pkg.sv
// Shared constants, frame kind type and register reset/protection tables
// for the frame-multiplexed serial port. Assumes a fixed 16-bit frame.
package fsp_pkg;

    localparam int WORD_W   = 16;
    localparam int ADDR_W   = 7;
    localparam int DATA_W   = 8;
    localparam int MODE_REG = 1;
    localparam int MODE_BIT = 0;

    typedef enum logic {
        FRM_DATA = 1'b0,
        FRM_CTRL = 1'b1
    } frame_kind_e;

    // Reset value of register idx.
    function automatic logic [DATA_W-1:0] reg_default(input int idx);
        case (idx)
            0:       return 8'h08;
            2:       return 8'hFF;
            3:       return 8'hFF;
            6:       return 8'h50;
            9:       return 8'h0A;
            10:      return 8'h22;
            11:      return 8'h12;
            13:      return 8'hC0;
            default: return 8'h00;
        endcase
    endfunction

    // Bits of register idx that writes cannot change.
    function automatic logic [DATA_W-1:0] reg_ro_mask(input int idx);
        return (idx == 6) ? 8'hF0 : 8'h00;
    endfunction

endpackage

// File: rtl/fsp_shifter.sv
// Bit-level framing: counts the sixteen bit times after a frame-sync pulse,
// shifts sdin in, shifts the outgoing word out, and swaps in register read
// data at mid-frame of a control frame. Assumes fs is a single-cycle pulse.
module fsp_shifter
    import fsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs,
    input  logic              sdin,
    input  logic              cur_ctrl,
    input  logic              load_ctrl,
    input  logic [WORD_W-1:0] rx_word,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sdout,
    output logic              frame_done,
    output logic [WORD_W-1:0] frame_word,
    output logic [ADDR_W-1:0] rd_addr
);

    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-2:0] rx_sh;
    logic [WORD_W-1:0] tx_sh;

    // Bit counter, input shifter and output shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            rx_sh <= '0;
            tx_sh <= '0;
        end else begin
            if (cnt != '0) begin
                rx_sh <= {rx_sh[WORD_W-3:0], sdin};
            end
            if (fs) begin
                cnt   <= CNT_FULL;
                tx_sh <= load_ctrl ? '0 : rx_word;
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
                if (cur_ctrl && cnt == CNT_ADDR) begin
                    tx_sh <= {rd_data, {(WORD_W-DATA_W){1'b0}}};
                end else begin
                    tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
                end
            end
        end
    end

    // Frame completion and word views for the sequencer and register file.
    always_comb begin
        frame_done = (cnt == CNT_LAST);
        frame_word = {rx_sh, sdin};
        rd_addr    = {rx_sh[ADDR_W-2:0], sdin};
        sdout      = tx_sh[WORD_W-1];
    end

    p_sync_reload_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fs |=> (cnt == CNT_FULL));
    p_count_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!fs && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/fsp_sequencer.sv
// Frame-kind tracking: decides whether the next frame is data or control,
// publishes the received transmit sample with a strobe, and raises register
// writes. Assumes frame_done pulses once on each frame's last bit edge.
module fsp_sequencer
    import fsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic [WORD_W-1:0] frame_word,
    input  logic              hc_mode,
    output logic              cur_ctrl,
    output logic              load_ctrl,
    output logic [WORD_W-1:0] tx_sample,
    output logic              tx_valid,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    frame_kind_e kind_q;
    frame_kind_e kind_next;

    // Next kind: control only after a data frame in alternation or on request.
    always_comb begin
        if (kind_q == FRM_CTRL) begin
            kind_next = FRM_DATA;
        end else if (hc_mode || frame_word[0]) begin
            kind_next = FRM_CTRL;
        end else begin
            kind_next = FRM_DATA;
        end
        cur_ctrl  = (kind_q == FRM_CTRL);
        load_ctrl = frame_done ? (kind_next == FRM_CTRL) : cur_ctrl;
        wr_en     = frame_done && cur_ctrl && !frame_word[WORD_W-1];
        wr_addr   = frame_word[WORD_W-2 -: ADDR_W];
        wr_data   = frame_word[DATA_W-1:0];
    end

    // Kind register and transmit sample output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q    <= FRM_DATA;
            tx_sample <= '0;
            tx_valid  <= 1'b0;
        end else begin
            tx_valid <= frame_done && !cur_ctrl;
            if (frame_done) begin
                kind_q <= kind_next;
                if (!cur_ctrl) begin
                    tx_sample <= frame_word;
                end
            end
        end
    end

    p_ctrl_then_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && cur_ctrl) |=> !cur_ctrl);
    p_sw_stays_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !cur_ctrl && !hc_mode && !frame_word[0]) |=> !cur_ctrl);
    p_alternate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !cur_ctrl && hc_mode) |=> cur_ctrl);
    p_strobe_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid);

endmodule

// File: rtl/fsp_regfile.sv
// Byte register file reached through control frames: reset defaults,
// write-protected bits, zero read-back outside the implemented range.
// Assumes a single write port and a combinational read port.
module fsp_regfile
    import fsp_pkg::*;
#(
    parameter int NUM_REGS = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              hc_mode
);

    logic [DATA_W-1:0] regs [NUM_REGS];

    // Register storage with reset defaults and protected bits.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (!rst_n) begin
                regs[i] <= reg_default(i);
            end else if (wr_en && wr_addr == ADDR_W'(i)) begin
                regs[i] <= (wr_data & ~reg_ro_mask(i)) | (reg_default(i) & reg_ro_mask(i));
            end
        end
    end

    // Read mux; unmatched addresses return zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
                rd_data = regs[i];
            end
        end
        hc_mode = regs[MODE_REG][MODE_BIT];
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
        localparam logic [DATA_W-1:0] RO = reg_ro_mask(g);
        p_hold_unwritten_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_addr == ADDR_W'(g)) |=> $stable(regs[g]));
        if (RO != '0) begin : g_ro
            p_ro_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_addr == ADDR_W'(g)) |=> ((regs[g] & RO) == $past(regs[g] & RO)));
        end
    end

endmodule

// File: rtl/fmux_serial_port.sv
// Top of the frame-multiplexed serial port: joins the bit shifter, the
// frame-kind sequencer and the register file. The serial clock is clk.
module fmux_serial_port
    import fsp_pkg::*;
#(
    parameter int NUM_REGS = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fs,
    input  logic        sdin,
    output logic        sdout,
    input  logic [15:0] rx_sample,
    output logic [15:0] tx_sample,
    output logic        tx_valid
);

    logic              cur_ctrl;
    logic              load_ctrl;
    logic              frame_done;
    logic [WORD_W-1:0] frame_word;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              hc_mode;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    fsp_shifter u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .fs         (fs),
        .sdin       (sdin),
        .cur_ctrl   (cur_ctrl),
        .load_ctrl  (load_ctrl),
        .rx_word    (rx_sample),
        .rd_data    (rd_data),
        .sdout      (sdout),
        .frame_done (frame_done),
        .frame_word (frame_word),
        .rd_addr    (rd_addr)
    );

    fsp_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .frame_word (frame_word),
        .hc_mode    (hc_mode),
        .cur_ctrl   (cur_ctrl),
        .load_ctrl  (load_ctrl),
        .tx_sample  (tx_sample),
        .tx_valid   (tx_valid),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    fsp_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .hc_mode (hc_mode)
    );

endmodule

// File: tb/fmux_serial_port_tb_top.sv
// Scoreboard bench: the frame driver predicts each frame from a reference
// model and queues expected transmit samples; a monitor pops them on strobes.
module fmux_serial_port_tb_top;

    localparam int NREG = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fs = 1'b0;
    logic        sdin = 1'b0;
    logic        sdout;
    logic [15:0] rx_sample = '0;
    logic [15:0] tx_sample;
    logic        tx_valid;

    int total = 0;
    int bad = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [7:0]  m_regs [128];
    logic        m_ctrl;

    always #2.5 clk = ~clk;

    fmux_serial_port #(.NUM_REGS(NREG)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fs        (fs),
        .sdin      (sdin),
        .sdout     (sdout),
        .rx_sample (rx_sample),
        .tx_sample (tx_sample),
        .tx_valid  (tx_valid)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: every strobe must match the oldest queued data word.
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected strobe", tx_sample, 16'h0000);
            end else begin
                automatic logic [15:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(tx_sample == e, t, tx_sample, e);
            end
        end
    end

    function automatic logic [7:0] def_val(input int a);
        case (a)
            0: return 8'h08;  2: return 8'hFF;  3: return 8'hFF;
            6: return 8'h50;  9: return 8'h0A;  10: return 8'h22;
            11: return 8'h12; 13: return 8'hC0;
            default: return 8'h00;
        endcase
    endfunction

    // Driver: predict the frame from the model, then shift it.
    task automatic xfer(input logic [15:0] w, input logic [15:0] rs, input string req);
        logic [15:0] exp_out;
        logic [15:0] got;
        logic [6:0]  a;
        a = w[14:8];
        if (!m_ctrl) begin
            exp_out = rs;
            exp_q.push_back(w);
            tag_q.push_back({req, " strobe word"});
            m_ctrl = m_regs[1][0] | w[0];
        end else begin
            exp_out = {8'h00, (int'(a) < NREG) ? m_regs[a] : 8'h00};
            if (!w[15] && int'(a) < NREG) begin
                m_regs[a] = (a == 7'd6) ? {4'h5, w[3:0]} : w[7:0];
            end
            m_ctrl = 1'b0;
        end
        @(negedge clk);
        fs = 1'b1;
        rx_sample = rs;
        sdin = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk);
            fs = 1'b0;
            sdin = w[i];
            got[i] = sdout;
        end
        @(negedge clk);
        sdin = 1'b0;
        check(got === exp_out, {req, " sdout word"}, got, exp_out);
    endtask

    task automatic reg_read(input logic [6:0] a, input logic [7:0] junk, input string req);
        if (!m_ctrl) xfer(16'h5A5B, 16'h1111, req);
        xfer({1'b1, a, junk}, 16'hDEAD, req);
    endtask

    task automatic reg_write(input logic [6:0] a, input logic [7:0] d, input string req);
        if (!m_ctrl) xfer(16'hC3C1, 16'h2222, req);
        xfer({1'b0, a, d}, 16'hBEEF, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 16'h0, 16'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) m_regs[i] = (i < NREG) ? def_val(i) : 8'h00;
        m_ctrl = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R13: reset state
        check(tx_valid == 1'b0, "R13 tx_valid after reset", {15'd0, tx_valid}, 16'h0);
        check(sdout == 1'b0, "R13 sdout after reset", {15'd0, sdout}, 16'h0);

        // R1 R2 R3 R13: first frames are data
        xfer(16'h1234, 16'hABCD, "R1 R2 R3 R13 first data");
        xfer(16'hFFFE, 16'h0F0F, "R2 R3 data");
        xfer(16'h8000, 16'h8001, "R1 R3 data edges");

        // R10 R12 R5: defaults and unimplemented read
        for (int a = 0; a < 16; a++) reg_read(7'(a), 8'h00, "R5 R10 R12 default read");
        reg_read(7'h7F, 8'h00, "R12 top address read");

        // R4 R5: write then read back
        reg_write(7'd2, 8'h3C, "R4 write");
        reg_read(7'd2, 8'h00, "R4 R5 read back");
        // R6: read with junk data leaves register alone
        reg_read(7'd2, 8'h55, "R6 read with data bits");
        reg_read(7'd2, 8'hAA, "R6 read again");
        // R11: protected nibble
        reg_write(7'd6, 8'hAB, "R11 write rev");
        reg_read(7'd6, 8'h00, "R11 rev nibble");
        // R12: writes above range ignored
        reg_write(7'h40, 8'h77, "R12 write high");
        reg_read(7'h40, 8'h00, "R12 read high");
        reg_write(7'd15, 8'h99, "R12 write 0x0F");
        reg_read(7'd15, 8'h00, "R12 read 0x0F");

        // R7: low bit clear keeps data; register-looking word is a sample
        xfer(16'h0100, 16'h3333, "R7 data lsb0");
        xfer(16'h0155, 16'h4444, "R7 data again");
        reg_read(7'd1, 8'h00, "R7 mode reg untouched");

        // R8: enter alternation, data bit 0 ignored
        reg_write(7'd1, 8'h01, "R8 set mode");
        xfer(16'h0000, 16'h5555, "R8 data lsb0");
        xfer({1'b1, 7'd1, 8'h00}, 16'hDEAD, "R8 forced control read");
        xfer(16'h0002, 16'h6666, "R8 data");
        xfer({1'b0, 7'd3, 8'h11}, 16'hDEAD, "R8 forced control write");
        xfer(16'h7770, 16'h7777, "R8 data");
        xfer({1'b1, 7'd3, 8'h00}, 16'hDEAD, "R8 read back");

        // R9: recovery starting in data phase
        xfer(16'h0100, 16'h8888, "R9 clear 1 data phase");
        xfer(16'h0100, 16'h9999, "R9 clear 2");
        xfer(16'h0000, 16'hAAAA, "R9 sw data");
        xfer(16'h0000, 16'hBBBB, "R9 sw data 2");
        reg_read(7'd1, 8'h00, "R9 mode cleared");

        // R9: recovery starting in control phase
        reg_write(7'd1, 8'h01, "R9 set mode");
        xfer(16'h0000, 16'hCCCC, "R9 data before control");
        xfer(16'h0100, 16'hDDDD, "R9 clear 1 control phase");
        xfer(16'h0100, 16'hEEEE, "R9 clear 2");
        xfer(16'h0000, 16'h1357, "R9 sw data");
        xfer(16'h0000, 16'h2468, "R9 sw data 2");
        reg_read(7'd1, 8'h00, "R9 mode cleared 2");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2 missing strobes", 16'(exp_q.size()), 16'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule